// File: doc/BRIEF.md
# Single-Line Bus Memory Protocol Decoder

This block is the device-side sequencer of a serial memory that hangs on an ordinary parallel processor bus and uses only one data line. The host never toggles a clock pin or sends an opcode. Every command is built from plain bus strobes. A cycle with chip enable and write enable low delivers one bit to the device. A cycle with chip enable and output enable low takes one bit from it. The decoder samples the three active-low strobes and the line into its own clock and classifies each finished bus cycle. From that stream of one-bit events it assembles commands: a resynchronising pattern, an address load, sequential byte reads and page data loads, plus a pattern that commits the loaded page.

Decoded page bytes go out on a byte strobe with their address, for a separate page-write controller. A single pulse tells that controller to begin the nonvolatile write. The controller reports back through a busy input. Read data comes from a memory array port that returns the byte at `rdAddr` in the same cycle. The shared data line is split into an input, an output value and an output enable.

Top module: `serial_bus_decoder`

## Requirements
- R1: A write bit is a bus cycle with chip enable and write enable low and output enable high. Its value is the line level last seen before the first of those two strobes goes high.
- R2: `dioOe` is 1 only while chip enable and output enable are low and write enable is high. After reset it is 0.
- R3: A cycle with write enable and output enable low at the same time, under chip enable, is never driven. It produces no event and leaves any read sequence where it was.
- R4: Read, write 0, read is the resync pattern. It abandons any load or read in progress and sets the write-permission latch. Reads then return 1 until an address has been loaded. Reads also return 1 after power-up.
- R5: An address is 16 consecutive write bits, most significant first. The loaded value appears on `rdAddr`, masked to the array width (14 bits by default).
- R6: Read cycles that follow a complete address return the addressed byte, bit 7 first.
- R7: After every eighth read bit the read address advances by one. It wraps from the top of the array (0x3FFF by default) to 0.
- R8: A write of 1 during sequential reading ends it. Later reads return 1.
- R9: Write bits that follow a complete address are page data. Each eighth bit emits one `pgDataValid` pulse carrying the byte, MSB first, and its address. The address advances by one and wraps inside its 32-byte page.
- R10: Read, write 1, read after a page load pulses `pgStart` once. This happens only if the permission latch is set and at least one whole byte was loaded with no leftover bits. The pulse clears the latch.
- R11: A page load that ends on a partial byte, or has no whole byte, starts nothing and clears the permission latch.
- R12: While `nvBusy` is 1, every read returns 0. All bus events, the resync pattern included, are ignored and no strobe is emitted. Reads return 1 once `nvBusy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busCeN | input | 1 | Chip enable strobe, active low, asynchronous to clk |
| busOeN | input | 1 | Output enable strobe, active low |
| busWeN | input | 1 | Write enable strobe, active low |
| dioIn | input | 1 | Level on the shared data line |
| dioOut | output | 1 | Value to drive on the data line |
| dioOe | output | 1 | Drive enable for the data line |
| rdAddr | output | 16 | Array read address |
| rdData | input | 8 | Array byte at rdAddr, same cycle |
| pgAddr | output | 16 | Address of the page byte being delivered |
| pgData | output | 8 | Page byte being delivered |
| pgDataValid | output | 1 | One-cycle pulse: pgAddr/pgData valid |
| pgStart | output | 1 | One-cycle pulse: commit the loaded page |
| nvBusy | input | 1 | Nonvolatile write in progress |

## Verification
The checks inside the RTL assume that every bus strobe holds each level for several clocks. They also assume idle time with all strobes high between cycles, a combinational `rdData`, and `nvBusy` raised only by the page-write controller after a start pulse. The drive check compares `dioOe` with the strobe pins two clocks earlier, so it relies on strobes that do not glitch within the synchroniser window. The stimulus keeps every phase at four clocks with a five-clock gap. It models the array as a fixed function of the address and raises busy only after it has counted a start pulse.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_W0,
    EV_W1,
    EV_RD
  } busEvt_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_READY,
    ST_READ,
    ST_PAGE,
    ST_PGEND,
    ST_PGARM
  } seqState_t;

  typedef struct packed {
    logic clrCnt;
    logic addrBit;
    logic dataBit;
    logic readAdv;
    logic bitVal;
  } dpCmd_t;

endpackage

// File: rtl/sbd_bus_sampler.sv
module sbd_bus_sampler
  import sbd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    busCeN,
  input  logic    busOeN,
  input  logic    busWeN,
  input  logic    dioIn,
  output busEvt_t evt,
  output logic    rdActive
);

  // bit order {ce, oe, we, data}; strobes idle high
  localparam logic [3:0] IDLE_PINS = 4'b1110;

  logic [3:0] syncSh [SYNC_STAGES];
  logic ceS, oeS, weS, dS;
  logic wrNow, rdNow, badNow, actNow;
  logic actPrev, kindWr, bitLast, taint;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncSh[i] <= IDLE_PINS;
    end else begin
      syncSh[0] <= {busCeN, busOeN, busWeN, dioIn};
      for (int i = 1; i < SYNC_STAGES; i++) syncSh[i] <= syncSh[i-1];
    end
  end

  assign {ceS, oeS, weS, dS} = syncSh[SYNC_STAGES-1];

  assign wrNow  = !ceS && !weS && oeS;
  assign rdNow  = !ceS && !oeS && weS;
  assign badNow = !ceS && !weS && !oeS;
  assign actNow = wrNow || rdNow || badNow;
  assign rdActive = rdNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actPrev <= 1'b0;
      kindWr  <= 1'b0;
      bitLast <= 1'b0;
      taint   <= 1'b0;
      evt     <= EV_NONE;
    end else begin
      actPrev <= actNow;
      evt     <= EV_NONE;
      if (actNow && !actPrev) begin
        kindWr <= wrNow;
        taint  <= badNow;
      end else if (actNow) begin
        taint <= taint || badNow || (wrNow != kindWr);
      end
      if (wrNow) bitLast <= dS;
      if (!actNow && actPrev && !taint) begin
        if (kindWr) evt <= bitLast ? EV_W1 : EV_W0;
        else        evt <= EV_RD;
      end
    end
  end

endmodule

// File: rtl/sbd_datapath.sv
module sbd_datapath
  import sbd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int ARRAY_AW   = 14,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] pgAddr,
  output logic [7:0]        pgData,
  output logic              pgDataValid,
  output logic [2:0]        bitSel,
  output logic              addrLast,
  output logic              byteLast,
  output logic              atBoundary
);

  localparam int PB   = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(ADDR_W);
  localparam int HI_W = ADDR_W - ARRAY_AW;
  localparam logic [ARRAY_AW-1:0] ONE_A = 1;
  localparam logic [PB-1:0]       ONE_P = 1;
  localparam logic [CNT_W-1:0]    ONE_C = 1;

  logic [ADDR_W-1:0] addrReg, arrayNext, pageNext;
  logic [CNT_W-1:0]  cnt;
  logic [6:0]        shiftReg;

  assign arrayNext  = {{HI_W{1'b0}}, addrReg[ARRAY_AW-1:0] + ONE_A};
  assign pageNext   = {addrReg[ADDR_W-1:PB], addrReg[PB-1:0] + ONE_P};
  assign rdAddr     = {{HI_W{1'b0}}, addrReg[ARRAY_AW-1:0]};
  assign bitSel     = cnt[2:0];
  assign addrLast   = (cnt == CNT_W'(ADDR_W - 1));
  assign byteLast   = (cnt[2:0] == 3'd7);
  assign atBoundary = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg     <= '0;
      cnt         <= '0;
      shiftReg    <= '0;
      pgAddr      <= '0;
      pgData      <= '0;
      pgDataValid <= 1'b0;
    end else begin
      pgDataValid <= 1'b0;
      if (cmd.clrCnt) begin
        cnt <= '0;
      end else if (cmd.addrBit) begin
        addrReg <= {addrReg[ADDR_W-2:0], cmd.bitVal};
        cnt     <= addrLast ? '0 : cnt + ONE_C;
      end else if (cmd.dataBit) begin
        shiftReg <= {shiftReg[5:0], cmd.bitVal};
        if (byteLast) begin
          pgDataValid <= 1'b1;
          pgAddr      <= addrReg;
          pgData      <= {shiftReg, cmd.bitVal};
          addrReg     <= pageNext;
          cnt         <= '0;
        end else begin
          cnt <= cnt + ONE_C;
        end
      end else if (cmd.readAdv) begin
        if (byteLast) begin
          cnt     <= '0;
          addrReg <= arrayNext;
        end else begin
          cnt <= cnt + ONE_C;
        end
      end
    end
  end

  // a byte takes eight separate bus cycles, so strobes never run back to back
  assert_byte_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    pgDataValid |=> !pgDataValid);

endmodule

// File: rtl/sbd_ctrl.sv
module sbd_ctrl
  import sbd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  busEvt_t evt,
  input  logic    nvBusy,
  input  logic    addrLast,
  input  logic    byteLast,
  input  logic    atBoundary,
  output dpCmd_t  cmd,
  output logic    readMode,
  output logic    pgStart
);

  seqState_t state, stateNx;
  busEvt_t   hist1, hist2;
  logic      wrLatch, latchNx, loadedAny, loadedNx, pageOk, pageOkNx, startNx;
  logic      take, isWr, isRd, resetHit;

  assign take     = (evt != EV_NONE) && !nvBusy;
  assign isWr     = (evt == EV_W0) || (evt == EV_W1);
  assign isRd     = (evt == EV_RD);
  assign resetHit = isRd && (hist1 == EV_W0) && (hist2 == EV_RD);
  assign readMode = (state == ST_READY) || (state == ST_READ);

  always_comb begin
    stateNx  = state;
    latchNx  = wrLatch;
    loadedNx = loadedAny;
    pageOkNx = pageOk;
    startNx  = 1'b0;
    cmd      = '0;
    cmd.bitVal = (evt == EV_W1);
    if (take) begin
      if (resetHit) begin
        stateNx    = ST_ADDR;
        latchNx    = 1'b1;
        loadedNx   = 1'b0;
        cmd.clrCnt = 1'b1;
      end else begin
        unique case (state)
          ST_IDLE: if (isWr) begin
            stateNx     = ST_ADDR;
            cmd.addrBit = 1'b1;
          end
          ST_ADDR: if (isWr) begin
            cmd.addrBit = 1'b1;
            if (addrLast) stateNx = ST_READY;
          end else begin
            stateNx    = ST_IDLE;
            cmd.clrCnt = 1'b1;
          end
          ST_READY: if (isRd) begin
            stateNx     = ST_READ;
            cmd.readAdv = 1'b1;
          end else begin
            stateNx     = ST_PAGE;
            cmd.dataBit = 1'b1;
            loadedNx    = 1'b0;
          end
          ST_READ: if (isRd) begin
            cmd.readAdv = 1'b1;
          end else begin
            stateNx    = ST_IDLE;
            cmd.clrCnt = 1'b1;
          end
          ST_PAGE: if (isWr) begin
            cmd.dataBit = 1'b1;
            if (byteLast) loadedNx = 1'b1;
          end else begin
            stateNx  = ST_PGEND;
            pageOkNx = loadedAny && atBoundary;
          end
          ST_PGEND: begin
            stateNx = (evt == EV_W1) ? ST_PGARM : ST_IDLE;
            if (evt != EV_W1) cmd.clrCnt = 1'b1;
          end
          ST_PGARM: begin
            if (isRd) begin
              startNx = wrLatch && pageOk;
              latchNx = 1'b0;
            end
            stateNx    = ST_IDLE;
            cmd.clrCnt = 1'b1;
          end
          default: begin
            stateNx    = ST_IDLE;
            cmd.clrCnt = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      hist1     <= EV_NONE;
      hist2     <= EV_NONE;
      wrLatch   <= 1'b0;
      loadedAny <= 1'b0;
      pageOk    <= 1'b0;
      pgStart   <= 1'b0;
    end else begin
      state     <= stateNx;
      wrLatch   <= latchNx;
      loadedAny <= loadedNx;
      pageOk    <= pageOkNx;
      pgStart   <= startNx;
      if (take) begin
        hist1 <= evt;
        hist2 <= hist1;
      end
    end
  end

  assert_start_clears_latch_R10: assert property (@(posedge clk) disable iff (!rstN)
    pgStart |-> (!wrLatch && $past(wrLatch)));

  assert_no_start_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    $past(nvBusy) |-> !pgStart);

endmodule

// File: rtl/serial_bus_decoder.sv
module serial_bus_decoder
  import sbd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int ARRAY_AW    = 14,
  parameter int PAGE_BYTES  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCeN,
  input  logic              busOeN,
  input  logic              busWeN,
  input  logic              dioIn,
  output logic              dioOut,
  output logic              dioOe,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData,
  output logic [ADDR_W-1:0] pgAddr,
  output logic [7:0]        pgData,
  output logic              pgDataValid,
  output logic              pgStart,
  input  logic              nvBusy
);

  busEvt_t evt;
  dpCmd_t  cmd;
  logic    rdActive, readMode, addrLast, byteLast, atBoundary;
  logic [2:0] bitSel;

  sbd_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rstN(rstN), .busCeN(busCeN), .busOeN(busOeN), .busWeN(busWeN),
    .dioIn(dioIn), .evt(evt), .rdActive(rdActive)
  );

  sbd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .nvBusy(nvBusy), .addrLast(addrLast),
    .byteLast(byteLast), .atBoundary(atBoundary), .cmd(cmd),
    .readMode(readMode), .pgStart(pgStart)
  );

  sbd_datapath #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rdAddr(rdAddr), .pgAddr(pgAddr),
    .pgData(pgData), .pgDataValid(pgDataValid), .bitSel(bitSel),
    .addrLast(addrLast), .byteLast(byteLast), .atBoundary(atBoundary)
  );

  // busy status wins, then array data (MSB first), else idle-high
  assign dioOe  = rdActive;
  assign dioOut = nvBusy ? 1'b0 : (readMode ? rdData[~bitSel] : 1'b1);

  assert_drive_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    dioOe |-> $past(!busCeN && !busOeN && busWeN, SYNC_STAGES));

  assert_busy_reads_low_R12: assert property (@(posedge clk) disable iff (!rstN)
    (dioOe && nvBusy) |-> !dioOut);

endmodule

// File: tb/serial_bus_decoder_bench.sv
module serial_bus_decoder_bench;

  typedef struct {
    logic  v;
    string req;
  } expBit_t;

  typedef struct {
    logic [15:0] a;
    logic [7:0]  d;
  } expByte_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busCeN = 1'b1, busOeN = 1'b1, busWeN = 1'b1, dioIn = 1'b0;
  logic nvBusy = 1'b0;
  logic dioOut, dioOe, pgDataValid, pgStart;
  logic [15:0] rdAddr, pgAddr;
  logic [7:0] rdData, pgData;

  int total = 0;
  int bad = 0;
  int startCnt = 0;
  expBit_t  bitQ[$];
  expByte_t byteQ[$];
  event smp;

  always #10 clk = ~clk;

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5;
  endfunction

  assign rdData = memByte(rdAddr);

  serial_bus_decoder u_serial_bus_decoder (
    .clk(clk), .rstN(rstN), .busCeN(busCeN), .busOeN(busOeN), .busWeN(busWeN),
    .dioIn(dioIn), .dioOut(dioOut), .dioOe(dioOe), .rdAddr(rdAddr),
    .rdData(rdData), .pgAddr(pgAddr), .pgData(pgData),
    .pgDataValid(pgDataValid), .pgStart(pgStart), .nvBusy(nvBusy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // read-bit monitor
  initial forever begin
    @(smp);
    if (bitQ.size() > 0) begin
      expBit_t it;
      it = bitQ.pop_front();
      check(dioOe === 1'b1 && dioOut === it.v, it.req, "read bit {oe,out}",
            {30'd0, dioOe, dioOut}, {30'd0, 1'b1, it.v});
    end
  end

  // page-byte and start monitor
  always @(negedge clk) begin
    if (pgStart) startCnt++;
    if (pgDataValid) begin
      if (byteQ.size() == 0) begin
        check(1'b0, "R9", "unexpected page byte", pgAddr, 0);
      end else begin
        expByte_t e;
        e = byteQ.pop_front();
        check(pgAddr === e.a && pgData === e.d, "R9", "page byte {addr,data}",
              {pgAddr, pgData}, {e.a, e.d});
      end
    end
  end

  task automatic busCyc(input bit isWr, input bit val, input bit illegal,
                        input bit chk, input logic exp, input string req);
    @(negedge clk);
    busCeN = 1'b0;
    dioIn  = val;
    if (illegal) begin busWeN = 1'b0; busOeN = 1'b0; end
    else if (isWr) busWeN = 1'b0;
    else busOeN = 1'b0;
    if (chk) bitQ.push_back('{v: exp, req: req});
    repeat (4) @(negedge clk);
    if (chk) -> smp;
    if (illegal) check(dioOe === 1'b0, "R3", "oe during illegal cycle", dioOe, 0);
    #1;
    busCeN = 1'b1; busWeN = 1'b1; busOeN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic wr(input bit b);
    busCyc(1'b1, b, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic rd(input logic exp, input string req);
    busCyc(1'b0, 1'b0, 1'b0, 1'b1, exp, req);
  endtask

  task automatic rdAny();
    busCyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic resync(input logic exp);
    rdAny();
    wr(1'b0);
    rd(exp, "R4");
  endtask

  task automatic sendAddr(input logic [15:0] a);
    for (int i = 15; i >= 0; i--) wr(a[i]);
  endtask

  task automatic sendByte(input logic [7:0] d, input logic [15:0] expA);
    byteQ.push_back('{a: expA, d: d});
    for (int i = 7; i >= 0; i--) wr(d[i]);
  endtask

  task automatic readByte(input logic [15:0] a, input string req);
    logic [7:0] m;
    m = memByte(a);
    for (int i = 7; i >= 0; i--) rd(m[i], req);
  endtask

  task automatic commit();
    rdAny();
    wr(1'b1);
    rdAny();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", "run timed out", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(dioOe === 1'b0, "R2", "oe in reset", dioOe, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(dioOe === 1'b0 && pgStart === 1'b0, "R2", "idle outputs", {dioOe, pgStart}, 0);

    rd(1'b1, "R4");               // power-up read idles high
    resync(1'b1);
    rd(1'b1, "R4");
    sendAddr(16'h1234);
    check(rdAddr === 16'h1234, "R5", "loaded address", rdAddr, 16'h1234); // also R1
    readByte(16'h1234, "R6");
    readByte(16'h1235, "R7");
    busCyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R3");  // illegal cycle in between
    readByte(16'h1236, "R3");
    wr(1'b1);                     // R8: end of sequential read
    rd(1'b1, "R8");
    rd(1'b1, "R8");

    resync(1'b1);
    sendAddr(16'h3FFF);
    readByte(16'h3FFF, "R7");
    check(rdAddr === 16'h0000, "R7", "rollover address", rdAddr, 0);
    readByte(16'h0000, "R7");

    resync(1'b1);
    sendAddr(16'h0105);
    sendByte(8'hC3, 16'h0105);
    sendByte(8'h3C, 16'h0106);
    commit();
    check(startCnt == 1, "R10", "start pulses", startCnt, 1);
    nvBusy = 1'b1;
    rd(1'b0, "R12");
    rdAny();
    wr(1'b0);
    rd(1'b0, "R12");              // resync during busy ignored
    rd(1'b0, "R12");
    check(startCnt == 1, "R12", "start pulses while busy", startCnt, 1);
    nvBusy = 1'b0;
    repeat (2) @(negedge clk);
    rd(1'b1, "R12");

    sendAddr(16'h011F);           // latch clear: no start expected
    sendByte(8'h11, 16'h011F);
    sendByte(8'h22, 16'h0100);    // R9 page wrap
    commit();
    check(startCnt == 1, "R10", "start without resync", startCnt, 1);

    resync(1'b1);
    sendAddr(16'h0200);
    sendByte(8'h5A, 16'h0200);
    commit();
    check(startCnt == 2, "R10", "start after resync", startCnt, 2);

    resync(1'b1);
    sendAddr(16'h0300);
    for (int i = 0; i < 5; i++) wr(i[0]);
    commit();
    check(startCnt == 2, "R11", "partial byte start", startCnt, 2);
    sendAddr(16'h0300);
    sendByte(8'h77, 16'h0300);
    commit();
    check(startCnt == 2, "R11", "latch cleared by bad commit", startCnt, 2);

    repeat (4) @(negedge clk);
    check(byteQ.size() == 0, "R9", "pending page bytes", byteQ.size(), 0);
    check(bitQ.size() == 0, "R6", "pending read bits", bitQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule